// File: doc/BRIEF.md
# Segmented RAM Write Packer

This block turns byte-addressed write requests into single-beat commands for a RAM whose write port is split into equal segments. A request carries a RAM select, a byte address, a length, a small identifier and a payload of up to one beat of bytes. The request goes into a small first-in first-out queue. The controller takes one request at a time and works out where the bytes land. The offset inside the beat is the low part of the byte address, and the row is the high part. The controller then shifts the payload into place and builds the byte-enable and segment-valid masks. It also copies the row into the address field of every segment.

The finished command is held on the RAM port until the RAM accepts it with ready. The block then clears the command and pulses a done output that carries the request's identifier. A request that would run past the end of the beat is never written: it is dropped with a one-cycle error pulse that also carries its identifier. A zero-length request is finished at once with a done pulse, and no command is issued for it.

The control is a two-state machine. `PK_IDLE` means no command is on the port. `PK_HOLD` means a command is driven and the block is waiting for ready. The transition IDLE→HOLD happens when a request is popped that is non-empty and fits in the beat. The transition HOLD→IDLE happens when ready is sampled high. A popped request that is oversize or empty leaves the machine in IDLE and produces only its error or done pulse.

Top module: `seg_wr_packer`

## Requirements
- R1: Requests are accepted when `req_valid` and `req_ready` are both high, and they are processed strictly in arrival order. `req_ready` is low only while the queue holds QUEUE_DEPTH (default 4) waiting entries.
- R2: The byte offset is `req_addr` modulo DATA_BYTES (the low 7 bits by default). Payload byte i (bits [8i+7:8i] of `req_data`) appears on `wr_data` lane offset+i (bits [8(offset+i)+7:8(offset+i)]).
- R3: `wr_be` has exactly the bits offset through offset+len-1 set, and every other bit is clear.
- R4: Bit s of `wr_valid` is set exactly when at least one of the lanes 16s..16s+15 is enabled in `wr_be`.
- R5: Every ROW_W-bit field of `wr_addr` (field s at bits [12s+11:12s]) carries `req_addr` divided by DATA_BYTES. `wr_sel` carries `req_sel` unchanged.
- R6: A data lane whose byte enable is clear is driven as zero.
- R7: A command stays unchanged while `wr_ready` is low. In the cycle after `wr_ready` is sampled high with a command present, `wr_valid`, `wr_be` and `wr_data` are zero and `done_valid` is high for one cycle with `done_id` equal to the request's id. At most one command is outstanding at any time.
- R8: A request with len > DATA_BYTES − offset produces no command. It raises `err_valid` for one cycle with `err_id` equal to its id, and the next queued request is then served.
- R9: A request with len = 0 produces no command and raises `done_valid` for one cycle with its id.
- R10: A synchronous active-high `rst` empties the queue and clears `wr_valid`, `wr_be`, `wr_data`, `done_valid` and `err_valid`. After reset, `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Queue can accept a request |
| req_sel | input | SEL_W (2) | RAM select |
| req_addr | input | ROW_W+7 (19) | Byte address |
| req_len | input | LEN_W (8) | Byte count |
| req_id | input | ID_W (4) | Request identifier |
| req_data | input | DATA_BYTES*8 (1024) | Payload, byte i at bits [8i+7:8i] |
| wr_sel | output | SEL_W (2) | RAM select for the command |
| wr_addr | output | SEG_COUNT*ROW_W (96) | Per-segment row address |
| wr_be | output | DATA_BYTES (128) | Per-byte write enable |
| wr_data | output | DATA_BYTES*8 (1024) | Write data |
| wr_valid | output | SEG_COUNT (8) | Per-segment valid |
| wr_ready | input | 1 | RAM accepts the command |
| done_valid | output | 1 | Write finished (one cycle) |
| done_id | output | ID_W (4) | Identifier of the finished request |
| err_valid | output | 1 | Request rejected as oversize (one cycle) |
| err_id | output | ID_W (4) | Identifier of the rejected request |

## Verification
The bench builds the block with its default parameters: a 128-byte beat in eight 16-byte segments, 12-bit rows and a queue four deep. The 128-lane width puts several cases within reach: offset 0 with a full-beat payload, the last lane at offset 127, runs that end exactly at the beat edge, and runs that cross one segment boundary or fill segments exactly. The 8-bit length field allows lengths far past the beat, which drive the oversize path. A depth of four lets five back-to-back pushes behind a stalled RAM fill the queue, which exercises backpressure and the order in which the queue drains.

// File: rtl/seg_wr_pkg.sv
package seg_wr_pkg;
    typedef enum logic [0:0] {
        PK_IDLE = 1'b0,
        PK_HOLD = 1'b1
    } pk_state_e;
endpackage

// File: rtl/seg_req_fifo.sv
module seg_req_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign dout  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            if (push && !pop) begin
                count <= count + 1'b1;
            end else if (pop && !push) begin
                count <= count - 1'b1;
            end
        end
    end
endmodule

// File: rtl/seg_lane_pack.sv
module seg_lane_pack #(
    parameter int DATA_BYTES = 128,
    parameter int SEG_COUNT  = 8,
    parameter int LEN_W      = 8,
    parameter int OFF_W      = 7
) (
    input  logic [OFF_W-1:0]        offset,
    input  logic [LEN_W-1:0]        len,
    input  logic [DATA_BYTES*8-1:0] payload,
    output logic [DATA_BYTES*8-1:0] lane_data,
    output logic [DATA_BYTES-1:0]   lane_be,
    output logic [SEG_COUNT-1:0]    seg_valid
);
    localparam int SEG_BYTES = DATA_BYTES / SEG_COUNT;

    logic [DATA_BYTES*8-1:0] shifted;
    assign shifted = payload << {offset, 3'b000};

    for (genvar j = 0; j < DATA_BYTES; j++) begin : g_lane
        assign lane_be[j] = (32'(j) >= 32'(offset)) &&
                            ((32'(j) - 32'(offset)) < 32'(len));
        assign lane_data[8*j +: 8] = lane_be[j] ? shifted[8*j +: 8] : 8'h00;
    end

    for (genvar s = 0; s < SEG_COUNT; s++) begin : g_seg
        assign seg_valid[s] = |lane_be[s*SEG_BYTES +: SEG_BYTES];
    end
endmodule

// File: rtl/seg_wr_packer.sv
module seg_wr_packer
    import seg_wr_pkg::*;
#(
    parameter int DATA_BYTES  = 128,
    parameter int SEG_COUNT   = 8,
    parameter int ROW_W       = 12,
    parameter int LEN_W       = 8,
    parameter int ID_W        = 4,
    parameter int SEL_W       = 2,
    parameter int QUEUE_DEPTH = 4,
    localparam int OFF_W      = $clog2(DATA_BYTES),
    localparam int ADDR_W     = ROW_W + OFF_W,
    localparam int DATA_W     = DATA_BYTES * 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [SEL_W-1:0]           req_sel,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [LEN_W-1:0]           req_len,
    input  logic [ID_W-1:0]            req_id,
    input  logic [DATA_W-1:0]          req_data,
    output logic [SEL_W-1:0]           wr_sel,
    output logic [SEG_COUNT*ROW_W-1:0] wr_addr,
    output logic [DATA_BYTES-1:0]      wr_be,
    output logic [DATA_W-1:0]          wr_data,
    output logic [SEG_COUNT-1:0]       wr_valid,
    input  logic                       wr_ready,
    output logic                       done_valid,
    output logic [ID_W-1:0]            done_id,
    output logic                       err_valid,
    output logic [ID_W-1:0]            err_id
);
    localparam int ENTRY_W = SEL_W + ADDR_W + LEN_W + ID_W + DATA_W;

    pk_state_e state, state_nx;

    logic               q_empty, q_full, q_push, q_pop;
    logic [ENTRY_W-1:0] q_head;
    logic [SEL_W-1:0]   h_sel;
    logic [ADDR_W-1:0]  h_addr;
    logic [LEN_W-1:0]   h_len;
    logic [ID_W-1:0]    h_id;
    logic [DATA_W-1:0]  h_data;
    logic [OFF_W-1:0]   h_off;
    logic [ROW_W-1:0]   h_row;
    logic               h_fits, h_empty_len, take;
    logic [ID_W-1:0]    cur_id;

    logic [DATA_W-1:0]     pk_data;
    logic [DATA_BYTES-1:0] pk_be;
    logic [SEG_COUNT-1:0]  pk_seg;

    assign req_ready = !q_full;
    assign q_push    = req_valid && !q_full;

    seg_req_fifo #(
        .WIDTH (ENTRY_W),
        .DEPTH (QUEUE_DEPTH)
    ) u_queue (
        .clk   (clk),
        .rst   (rst),
        .push  (q_push),
        .din   ({req_sel, req_addr, req_len, req_id, req_data}),
        .pop   (q_pop),
        .dout  (q_head),
        .empty (q_empty),
        .full  (q_full)
    );

    assign {h_sel, h_addr, h_len, h_id, h_data} = q_head;
    assign h_off       = h_addr[OFF_W-1:0];
    assign h_row       = h_addr[ADDR_W-1:OFF_W];
    assign h_fits      = (32'(h_len) + 32'(h_off)) <= 32'(DATA_BYTES);
    assign h_empty_len = (h_len == '0);
    assign take        = (state == PK_IDLE) && !q_empty;
    assign q_pop       = take;

    seg_lane_pack #(
        .DATA_BYTES (DATA_BYTES),
        .SEG_COUNT  (SEG_COUNT),
        .LEN_W      (LEN_W),
        .OFF_W      (OFF_W)
    ) u_pack (
        .offset    (h_off),
        .len       (h_len),
        .payload   (h_data),
        .lane_data (pk_data),
        .lane_be   (pk_be),
        .seg_valid (pk_seg)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            PK_IDLE: if (take && h_fits && !h_empty_len) state_nx = PK_HOLD;
            PK_HOLD: if (wr_ready) state_nx = PK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PK_IDLE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_sel     <= '0;
            wr_addr    <= '0;
            wr_be      <= '0;
            wr_data    <= '0;
            wr_valid   <= '0;
            done_valid <= 1'b0;
            done_id    <= '0;
            err_valid  <= 1'b0;
            err_id     <= '0;
            cur_id     <= '0;
        end else begin
            done_valid <= 1'b0;
            err_valid  <= 1'b0;
            unique case (state)
                PK_IDLE: begin
                    if (take) begin
                        if (!h_fits) begin
                            err_valid <= 1'b1;
                            err_id    <= h_id;
                        end else if (h_empty_len) begin
                            done_valid <= 1'b1;
                            done_id    <= h_id;
                        end else begin
                            wr_sel   <= h_sel;
                            wr_addr  <= {SEG_COUNT{h_row}};
                            wr_be    <= pk_be;
                            wr_data  <= pk_data;
                            wr_valid <= pk_seg;
                            cur_id   <= h_id;
                        end
                    end
                end
                PK_HOLD: begin
                    if (wr_ready) begin
                        wr_valid   <= '0;
                        wr_be      <= '0;
                        wr_data    <= '0;
                        done_valid <= 1'b1;
                        done_id    <= cur_id;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/seg_wr_packer_chk.sv
module seg_wr_packer_chk #(
    parameter int DATA_BYTES = 128,
    parameter int SEG_COUNT  = 8,
    parameter int ROW_W      = 12
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       wr_ready,
    input logic [SEG_COUNT-1:0]       wr_valid,
    input logic [DATA_BYTES-1:0]      wr_be,
    input logic [DATA_BYTES*8-1:0]    wr_data,
    input logic [SEG_COUNT*ROW_W-1:0] wr_addr,
    input logic                       done_valid,
    input logic                       err_valid
);
    localparam int SEG_BYTES = DATA_BYTES / SEG_COUNT;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (|wr_valid && !wr_ready) |=> ($stable(wr_be) && $stable(wr_data) && $stable(wr_addr) && $stable(wr_valid))); // R7

    AST_CLEAR_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
        (|wr_valid && wr_ready) |=> (done_valid && wr_valid == '0 && wr_be == '0)); // R7

    AST_ERR_NO_CMD: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> (wr_valid == '0)); // R8

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        !(err_valid && done_valid)); // R8

    for (genvar s = 0; s < SEG_COUNT; s++) begin : g_seg_chk
        AST_SEG_COVER: assert property (@(posedge clk) disable iff (rst)
            wr_valid[s] == (|wr_be[s*SEG_BYTES +: SEG_BYTES])); // R4
        AST_ROW_SAME: assert property (@(posedge clk) disable iff (rst)
            wr_addr[s*ROW_W +: ROW_W] == wr_addr[ROW_W-1:0]); // R5
    end

    for (genvar j = 0; j < DATA_BYTES; j++) begin : g_lane_chk
        AST_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (rst)
            !wr_be[j] |-> (wr_data[8*j +: 8] == 8'h00)); // R6
    end
endmodule

bind seg_wr_packer seg_wr_packer_chk #(
    .DATA_BYTES (DATA_BYTES),
    .SEG_COUNT  (SEG_COUNT),
    .ROW_W      (ROW_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_ready   (wr_ready),
    .wr_valid   (wr_valid),
    .wr_be      (wr_be),
    .wr_data    (wr_data),
    .wr_addr    (wr_addr),
    .done_valid (done_valid),
    .err_valid  (err_valid)
);

// File: tb/tb_seg_wr_packer.sv
module tb_seg_wr_packer;
    localparam int CLK_PERIOD = 10;
    localparam int NB  = 128;
    localparam int NS  = 8;
    localparam int RW  = 12;
    localparam int AW  = 19;
    localparam int NV  = 10;

    // vector: {byte address, length, id}
    localparam logic [30:0] VEC [NV] = '{
        {19'd640,    8'd16,  4'd1},
        {19'd37255,  8'd20,  4'd2},
        {19'd524160, 8'd128, 4'd3},
        {19'd255,    8'd1,   4'd4},
        {19'd383,    8'd2,   4'd5},
        {19'd996,    8'd28,  4'd6},
        {19'd0,      8'd0,   4'd7},
        {19'd1216,   8'd200, 4'd8},
        {19'd1295,   8'd2,   4'd9},
        {19'd524208, 8'd32,  4'd10}
    };

    logic            clk = 0;
    logic            rst = 1;
    logic            req_valid = 0;
    logic            req_ready;
    logic [1:0]      req_sel = 0;
    logic [AW-1:0]   req_addr = 0;
    logic [7:0]      req_len = 0;
    logic [3:0]      req_id = 0;
    logic [NB*8-1:0] req_data = 0;
    logic [1:0]      wr_sel;
    logic [NS*RW-1:0] wr_addr;
    logic [NB-1:0]   wr_be;
    logic [NB*8-1:0] wr_data;
    logic [NS-1:0]   wr_valid;
    logic            wr_ready = 0;
    logic            done_valid;
    logic [3:0]      done_id;
    logic            err_valid;
    logic [3:0]      err_id;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_wr_packer dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_sel(req_sel), .req_addr(req_addr), .req_len(req_len), .req_id(req_id),
        .req_data(req_data), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_be(wr_be),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .done_valid(done_valid), .done_id(done_id), .err_valid(err_valid), .err_id(err_id)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [NB*8-1:0] act, input logic [NB*8-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [NB*8-1:0] mk_payload(input logic [3:0] id);
        logic [NB*8-1:0] p = '0;
        for (int i = 0; i < NB; i++) p[8*i +: 8] = 8'(id * 16 + i * 3 + 1);
        return p;
    endfunction

    task automatic push(input logic [AW-1:0] a, input logic [7:0] l, input logic [3:0] id);
        @(negedge clk);
        req_addr = a; req_len = l; req_id = id; req_sel = id[1:0];
        req_data = mk_payload(id);
        req_valid = 1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 0;
    endtask

    // waits at negedges for a command, done or error; returns 0 on timeout
    task automatic wait_outcome(output bit seen);
        seen = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (|wr_valid || done_valid || err_valid) begin
                seen = 1;
                break;
            end
        end
    endtask

    task automatic check_cmd(input logic [AW-1:0] a, input logic [7:0] l, input logic [3:0] id);
        logic [NB-1:0]   eb = '0;
        logic [NB*8-1:0] ed = '0;
        logic [NS-1:0]   ev = '0;
        logic [NB*8-1:0] p = mk_payload(id);
        int off = int'(a[6:0]);
        for (int i = 0; i < int'(l); i++) begin
            eb[off + i] = 1'b1;
            ed[8*(off + i) +: 8] = p[8*i +: 8];
            ev[(off + i) / 16] = 1'b1;
        end
        check(wr_be == eb, "R3", "byte enables", NB*8'(wr_be), NB*8'(eb));
        check(wr_data == ed, "R2", "lane data (R6 zero lanes)", wr_data, ed);
        check(wr_valid == ev, "R4", "segment valid", NB*8'(wr_valid), NB*8'(ev));
        for (int s = 0; s < NS; s++)
            check(wr_addr[s*RW +: RW] == a[AW-1:7], "R5", "segment row",
                  NB*8'(wr_addr[s*RW +: RW]), NB*8'(a[AW-1:7]));
        check(wr_sel == id[1:0], "R5", "select", NB*8'(wr_sel), NB*8'(id[1:0]));
    endtask

    // full handling of one popped request, starting after push
    task automatic handle(input logic [AW-1:0] a, input logic [7:0] l, input logic [3:0] id,
                          input int hold);
        bit seen;
        bit fits = (int'(l) + int'(a[6:0])) <= NB;
        wait_outcome(seen);
        check(seen, "R1", "outcome seen", NB*8'(seen), 1);
        if (!fits) begin
            check(err_valid && err_id == id, "R8", "error pulse id",
                  NB*8'({err_valid, err_id}), NB*8'({1'b1, id}));
            check(wr_valid == 0, "R8", "no command on error", NB*8'(wr_valid), 0);
            @(negedge clk);
            check(!err_valid && wr_valid == 0, "R8", "error one cycle, no write",
                  NB*8'({err_valid, wr_valid}), 0);
        end else if (l == 0) begin
            check(done_valid && done_id == id, "R9", "zero-length done",
                  NB*8'({done_valid, done_id}), NB*8'({1'b1, id}));
            check(wr_valid == 0, "R9", "no command for zero length", NB*8'(wr_valid), 0);
        end else begin
            check_cmd(a, l, id);
            for (int h = 0; h < hold; h++) begin
                @(negedge clk);
                check(!done_valid, "R7", "no done while stalled", NB*8'(done_valid), 0);
                check_cmd(a, l, id);
            end
            wr_ready = 1;
            @(negedge clk);
            wr_ready = 0;
            check(done_valid && done_id == id, "R7", "done after ready",
                  NB*8'({done_valid, done_id}), NB*8'({1'b1, id}));
            check(wr_valid == 0 && wr_be == 0 && wr_data == 0, "R7", "command cleared",
                  NB*8'({wr_valid, wr_be}), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(wr_valid == 0 && wr_be == 0 && !done_valid && !err_valid, "R10",
              "reset outputs", NB*8'({wr_valid, wr_be}), 0);
        check(req_ready == 1, "R10", "ready after reset", NB*8'(req_ready), 1);

        // table walk
        for (int v = 0; v < NV; v++) begin
            push(VEC[v][30:12], VEC[v][11:4], VEC[v][3:0]);
            handle(VEC[v][30:12], VEC[v][11:4], VEC[v][3:0], 2);
        end

        // R1: fill queue behind a stalled command, then drain in order
        for (int k = 0; k < 5; k++) push(19'((11 + k) * 128 + k * 20), 8'd3, 4'(11 + k));
        @(negedge clk);
        check(req_ready == 0, "R1", "queue full backpressure", NB*8'(req_ready), 0);
        for (int k = 0; k < 5; k++)
            handle(19'((11 + k) * 128 + k * 20), 8'd3, 4'(11 + k), 1);
        check(req_ready == 1, "R1", "ready after drain", NB*8'(req_ready), 1);

        // R10: reset in the middle empties the queue
        push(19'd300, 8'd4, 4'd1);
        push(19'd400, 8'd4, 4'd2);
        push(19'd500, 8'd4, 4'd3);
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        check(wr_valid == 0 && wr_be == 0, "R10", "outputs cleared by reset",
              NB*8'({wr_valid, wr_be}), 0);
        check(req_ready == 1, "R10", "queue empty after reset", NB*8'(req_ready), 1);
        wr_ready = 1;
        begin
            bit any = 0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (|wr_valid || done_valid || err_valid) any = 1;
            end
            check(!any, "R10", "no stale requests after reset", NB*8'(any), 0);
        end
        wr_ready = 0;

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule